// File: doc/BRIEF.md
# Serial Command Receiver and Display RAM Writer

This block terminates a write-only, chip-select-framed serial link from a host controller for a dot-matrix character display. While the active-low select is asserted, bits are shifted in MSB first on each rising serial clock edge. When the select is released, the last eight bits shifted form one byte. The register-select line, sampled at that release, decides how the byte is used. When it is low, the byte is decoded as an instruction. When it is high, the byte is written to one of three external RAMs: character codes, icon bits or user glyph rows.

The serial pins are synchronised into the system clock domain and their edges are detected there. Instructions update the held mode state: LED port level, character and icon enables, contrast duty code, blink rate and targets, visible digit count, and a one-cycle shift strobe with its direction and targets. Address instructions load one of three pointers and select the RAM that later data bytes go to. Each data byte leaves as a single-cycle write on the RAM write port, and the active pointer then advances. The glyph pointer skips the unused eighth row of each glyph.

Top module: `vfd_cmd_rx`

## Requirements
- R1: Bits are shifted only on rising `sclk_i` edges while `csn_i` is low; clock edges while `csn_i` is high leave the shift register unchanged.
- R2: The shift register keeps its content across frames, and the byte used is always the last 8 bits shifted. A frame longer than 8 bits keeps only its last 8, and a shorter frame completes its byte with the tail of earlier bits.
- R3: `rsel_i` is sampled only at the rising edge of `csn_i`: 0 decodes the byte as an instruction, 1 writes it as RAM data, whatever `rsel_i` was during the frame.
- R4: Byte 0000001p sets `port_o` to p. Byte 000001id sets `icon_on_o` to i and `chr_on_o` to d.
- R5: Byte 00001ddd sets `duty_o` to ddd. Byte 01000ccc sets `digits_o` to ccc.
- R6: Byte 001rrrid sets `blink_rate_o` to rrr, `blink_icon_o` to i and `blink_chr_o` to d.
- R7: Byte 00010lid produces one single-cycle `shift_stb_o` pulse, with `shift_left_o`=l, `shift_icon_o`=i and `shift_chr_o`=d.
- R8: 1000aaaa loads the character pointer and selects target 0. 1001aaaa loads the icon pointer and selects target 1. 11aaaaaa loads the glyph pointer and selects target 2. Each data byte gives one `wr_en_o` pulse, with `wr_tgt_o` set to the target and `wr_addr_o` set to the pointer, zero-extended.
- R9: `wr_data_o` carries all 8 bits for target 0, only bits [1:0] for target 1 and only bits [4:0] for target 2; the upper bits are zero.
- R10: After each data write the active pointer advances by one. The 4-bit pointers wrap from 0Fh to 00h. The 6-bit glyph pointer skips any value whose low three bits are 111, so 06h goes to 08h and 3Eh goes to 00h.
- R11: After reset: all pointers are 0, the target is 0, `port_o` is 0, display and icon are off, duty, digit and blink codes are 0, blink targets are 0, and no write or shift pulse is active.
- R12: Any instruction byte not listed above (such as 00h, 01h, 18h, 48h or A5h) changes no mode output, no pointer and the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial shift clock |
| sdat_i | input | 1 | Serial data, MSB first |
| csn_i | input | 1 | Active-low frame select |
| rsel_i | input | 1 | Instruction (0) or RAM data (1) |
| wr_en_o | output | 1 | RAM write strobe, one cycle |
| wr_tgt_o | output | 2 | Write target: 0 character, 1 icon, 2 glyph |
| wr_addr_o | output | 6 | Write address |
| wr_data_o | output | 8 | Masked write data |
| port_o | output | 1 | LED port level |
| chr_on_o | output | 1 | Character display enable |
| icon_on_o | output | 1 | Icon display enable |
| duty_o | output | 3 | Contrast duty code |
| digits_o | output | 3 | Digit count code |
| blink_rate_o | output | 3 | Blink rate code |
| blink_chr_o | output | 1 | Blink applies to characters |
| blink_icon_o | output | 1 | Blink applies to icons |
| shift_stb_o | output | 1 | Shift request pulse |
| shift_left_o | output | 1 | Shift direction, 1 = left |
| shift_chr_o | output | 1 | Shift applies to characters |
| shift_icon_o | output | 1 | Shift applies to icons |

## Verification
The bench targets the glyph pointer at 06h and at 3Eh. A design that forgets the skip writes row 07h, and one that mishandles the carry lands on 3Fh or 40h rather than 00h. Overlong frames, short frames and clock pulses given while the select is high show whether the byte is really the last eight bits shifted under select: a design that clears the register per frame, or that keeps shifting while deselected, produces the wrong byte. The register-select line is flipped just before each frame closes, so a design that latches it at the start of the frame sends instructions to RAM or the reverse. Unlisted opcodes such as 00h and 01h are sent between known states, and a design that decodes them loosely changes the port, the enables or the pointer, which the next scored write then exposes.

// File: rtl/vfd_rx_pkg.sv
package vfd_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int NARROW_AW = 4;
  localparam int GLYPH_AW = 6;
  localparam int ICON_DW = 2;
  localparam int GLYPH_DW = 5;
  localparam int ROW_W = 3;

  typedef enum logic [1:0] {
    TGT_CHR   = 2'd0,
    TGT_ICON  = 2'd1,
    TGT_GLYPH = 2'd2
  } tgt_e;
endpackage

// File: rtl/vfd_rx_front.sv
module vfd_rx_front #(
  parameter int SYNC_N = 2,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              csn_i,
  input  logic              rsel_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              cmd_stb_o,
  output logic              data_stb_o
);
  // bit order in each stage: {rsel, sdat, sclk, csn}
  localparam logic [3:0] IDLE = 4'b0001;
  logic [3:0] stg [SYNC_N];
  logic sclk_q, csn_q;
  logic [BYTE_W-1:0] sh_q;
  logic [3:0] s;

  assign s = stg[SYNC_N-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SYNC_N; i++) stg[i] <= IDLE;
    end else begin
      stg[0] <= {rsel_i, sdat_i, sclk_i, csn_i};
      for (int i = 1; i < SYNC_N; i++) stg[i] <= stg[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
      sh_q   <= '0;
    end else begin
      sclk_q <= s[1];
      csn_q  <= s[0];
      if (s[1] && !sclk_q && !s[0]) sh_q <= {sh_q[BYTE_W-2:0], s[2]};
    end
  end

  assign byte_o     = sh_q;
  assign cmd_stb_o  = s[0] && !csn_q && !s[3];
  assign data_stb_o = s[0] && !csn_q && s[3];

  a_r1_hold_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s[0] |=> $stable(sh_q));
  a_r3_single_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_stb_o && data_stb_o));
endmodule

// File: rtl/vfd_rx_ctrl.sv
module vfd_rx_ctrl
  import vfd_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_stb_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              set_chr_o,
  output logic              set_icon_o,
  output logic              set_glyph_o,
  output logic              port_o,
  output logic              chr_on_o,
  output logic              icon_on_o,
  output logic [2:0]        duty_o,
  output logic [2:0]        digits_o,
  output logic [2:0]        blink_rate_o,
  output logic              blink_chr_o,
  output logic              blink_icon_o,
  output logic              shift_stb_o,
  output logic              shift_left_o,
  output logic              shift_chr_o,
  output logic              shift_icon_o
);
  logic op_port, op_onoff, op_duty, op_shift, op_blink, op_digits;

  always_comb begin
    {op_port, op_onoff, op_duty, op_shift, op_blink, op_digits} = '0;
    {set_chr_o, set_icon_o, set_glyph_o} = '0;
    if (cmd_stb_i) begin
      casez (byte_i)
        8'b11??????: set_glyph_o = 1'b1;
        8'b1000????: set_chr_o   = 1'b1;
        8'b1001????: set_icon_o  = 1'b1;
        8'b01000???: op_digits   = 1'b1;
        8'b001?????: op_blink    = 1'b1;
        8'b00010???: op_shift    = 1'b1;
        8'b00001???: op_duty     = 1'b1;
        8'b000001??: op_onoff    = 1'b1;
        8'b0000001?: op_port     = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_o <= 1'b0;
      {icon_on_o, chr_on_o} <= '0;
      duty_o <= '0;
      digits_o <= '0;
      {blink_rate_o, blink_icon_o, blink_chr_o} <= '0;
      shift_stb_o <= 1'b0;
      {shift_left_o, shift_icon_o, shift_chr_o} <= '0;
    end else begin
      shift_stb_o <= op_shift;
      if (op_port)   port_o <= byte_i[0];
      if (op_onoff)  {icon_on_o, chr_on_o} <= byte_i[1:0];
      if (op_duty)   duty_o <= byte_i[2:0];
      if (op_digits) digits_o <= byte_i[2:0];
      if (op_blink)  {blink_rate_o, blink_icon_o, blink_chr_o} <= byte_i[4:0];
      if (op_shift)  {shift_left_o, shift_icon_o, shift_chr_o} <= byte_i[2:0];
    end
  end

  a_r12_modes_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_stb_i |=> $stable({port_o, chr_on_o, icon_on_o, duty_o, digits_o,
                            blink_rate_o, blink_chr_o, blink_icon_o}));
  a_r7_shift_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_stb_o |=> !shift_stb_o);
endmodule

// File: rtl/vfd_rx_wr.sv
module vfd_rx_wr
  import vfd_rx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                data_stb_i,
  input  logic [BYTE_W-1:0]   byte_i,
  input  logic                set_chr_i,
  input  logic                set_icon_i,
  input  logic                set_glyph_i,
  output logic                wr_en_o,
  output logic [1:0]          wr_tgt_o,
  output logic [GLYPH_AW-1:0] wr_addr_o,
  output logic [BYTE_W-1:0]   wr_data_o
);
  tgt_e tgt_q;
  logic [NARROW_AW-1:0] chr_ptr_q, icon_ptr_q;
  logic [GLYPH_AW-1:0]  glyph_ptr_q, glyph_nxt;

  always_comb begin
    glyph_nxt = glyph_ptr_q + 1'b1;
    if (&glyph_nxt[ROW_W-1:0]) glyph_nxt = glyph_nxt + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= TGT_CHR;
      chr_ptr_q <= '0;
      icon_ptr_q <= '0;
      glyph_ptr_q <= '0;
      wr_en_o <= 1'b0;
      wr_tgt_o <= '0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (set_chr_i) begin
        tgt_q <= TGT_CHR;
        chr_ptr_q <= byte_i[NARROW_AW-1:0];
      end
      if (set_icon_i) begin
        tgt_q <= TGT_ICON;
        icon_ptr_q <= byte_i[NARROW_AW-1:0];
      end
      if (set_glyph_i) begin
        tgt_q <= TGT_GLYPH;
        glyph_ptr_q <= byte_i[GLYPH_AW-1:0];
      end
      if (data_stb_i) begin
        wr_en_o  <= 1'b1;
        wr_tgt_o <= tgt_q;
        unique case (tgt_q)
          TGT_ICON: begin
            wr_addr_o <= GLYPH_AW'(icon_ptr_q);
            wr_data_o <= BYTE_W'(byte_i[ICON_DW-1:0]);
            icon_ptr_q <= icon_ptr_q + 1'b1;
          end
          TGT_GLYPH: begin
            wr_addr_o <= glyph_ptr_q;
            wr_data_o <= BYTE_W'(byte_i[GLYPH_DW-1:0]);
            glyph_ptr_q <= glyph_nxt;
          end
          default: begin
            wr_addr_o <= GLYPH_AW'(chr_ptr_q);
            wr_data_o <= byte_i;
            chr_ptr_q <= chr_ptr_q + 1'b1;
          end
        endcase
      end
    end
  end

  a_r10_no_dead_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_tgt_o == TGT_GLYPH) |-> !(&glyph_ptr_q[ROW_W-1:0]));
  a_r8_write_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
  a_r8_valid_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> wr_tgt_o != 2'd3);
  a_r9_icon_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_tgt_o == TGT_ICON) |-> wr_data_o[BYTE_W-1:ICON_DW] == '0);
  a_r9_glyph_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_tgt_o == TGT_GLYPH) |-> wr_data_o[BYTE_W-1:GLYPH_DW] == '0);
endmodule

// File: rtl/vfd_cmd_rx.sv
module vfd_cmd_rx
  import vfd_rx_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       sdat_i,
  input  logic       csn_i,
  input  logic       rsel_i,
  output logic       wr_en_o,
  output logic [1:0] wr_tgt_o,
  output logic [5:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic       port_o,
  output logic       chr_on_o,
  output logic       icon_on_o,
  output logic [2:0] duty_o,
  output logic [2:0] digits_o,
  output logic [2:0] blink_rate_o,
  output logic       blink_chr_o,
  output logic       blink_icon_o,
  output logic       shift_stb_o,
  output logic       shift_left_o,
  output logic       shift_chr_o,
  output logic       shift_icon_o
);
  logic [BYTE_W-1:0] rx_byte;
  logic cmd_stb, data_stb, set_chr, set_icon, set_glyph;

  vfd_rx_front #(.SYNC_N(SYNC_N), .BYTE_W(BYTE_W)) i_front (
    .clk_i, .rst_ni, .sclk_i, .sdat_i, .csn_i, .rsel_i,
    .byte_o(rx_byte), .cmd_stb_o(cmd_stb), .data_stb_o(data_stb)
  );

  vfd_rx_ctrl i_ctrl (
    .clk_i, .rst_ni, .cmd_stb_i(cmd_stb), .byte_i(rx_byte),
    .set_chr_o(set_chr), .set_icon_o(set_icon), .set_glyph_o(set_glyph),
    .port_o, .chr_on_o, .icon_on_o, .duty_o, .digits_o,
    .blink_rate_o, .blink_chr_o, .blink_icon_o,
    .shift_stb_o, .shift_left_o, .shift_chr_o, .shift_icon_o
  );

  vfd_rx_wr i_wr (
    .clk_i, .rst_ni, .data_stb_i(data_stb), .byte_i(rx_byte),
    .set_chr_i(set_chr), .set_icon_i(set_icon), .set_glyph_i(set_glyph),
    .wr_en_o, .wr_tgt_o, .wr_addr_o, .wr_data_o
  );
endmodule

// File: tb/test_vfd_cmd_rx.sv
module test_vfd_cmd_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, csn = 1'b1, rsel = 1'b0;
  logic wr_en, port, chr_on, icon_on, blink_chr, blink_icon;
  logic shift_stb, shift_left, shift_chr, shift_icon;
  logic [1:0] wr_tgt;
  logic [5:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] duty, digits, blink_rate;

  int n_cmp = 0, n_bad = 0, n_shift = 0;
  bit done = 0;
  logic [15:0] sb_q[$];
  string sb_req[$];
  int m_tgt = 0, m_cp = 0, m_ip = 0, m_gp = 0;
  logic [2:0] sh_seen;

  always #10 clk = ~clk;

  vfd_cmd_rx i_vfd_cmd_rx (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdat_i(sdat), .csn_i(csn),
    .rsel_i(rsel), .wr_en_o(wr_en), .wr_tgt_o(wr_tgt), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .port_o(port), .chr_on_o(chr_on), .icon_on_o(icon_on),
    .duty_o(duty), .digits_o(digits), .blink_rate_o(blink_rate),
    .blink_chr_o(blink_chr), .blink_icon_o(blink_icon), .shift_stb_o(shift_stb),
    .shift_left_o(shift_left), .shift_chr_o(shift_chr), .shift_icon_o(shift_icon)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop scoreboard on every write pulse
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (sb_q.size() == 0) check("R8 unexpected write", {wr_tgt, wr_addr, wr_data}, 32'hffff);
      else check(sb_req.pop_front(), {wr_tgt, wr_addr, wr_data}, sb_q.pop_front());
    end
    if (rst_n && shift_stb) begin
      n_shift++;
      sh_seen = {shift_left, shift_icon, shift_chr};
    end
  end

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  // rsel is held inverted during the frame and set right before csn rises (R3)
  task automatic xfer(logic rs, logic [15:0] bits, int n);
    rsel = ~rs;
    csn = 1'b0;
    ticks(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = bits[i];
      ticks(4);
      sclk = 1'b1;
      ticks(4);
      sclk = 1'b0;
    end
    rsel = rs;
    ticks(4);
    csn = 1'b1;
    ticks(10);
  endtask

  task automatic instr(logic [7:0] b);
    if (b[7:4] == 4'h8) begin m_tgt = 0; m_cp = b[3:0]; end
    else if (b[7:4] == 4'h9) begin m_tgt = 1; m_ip = b[3:0]; end
    else if (b[7:6] == 2'b11) begin m_tgt = 2; m_gp = b[5:0]; end
    xfer(1'b0, {8'h0, b}, 8);
  endtask

  function automatic logic [15:0] expect_wr(logic [7:0] b);
    logic [15:0] e;
    case (m_tgt)
      1: begin e = {2'd1, m_ip[5:0], 6'd0, b[1:0]}; m_ip = (m_ip + 1) % 16; end
      2: begin
        e = {2'd2, m_gp[5:0], 3'd0, b[4:0]};
        m_gp = (m_gp + 1) % 64;
        if (m_gp % 8 == 7) m_gp = (m_gp + 1) % 64;
      end
      default: begin e = {2'd0, m_cp[5:0], b}; m_cp = (m_cp + 1) % 16; end
    endcase
    return e;
  endfunction

  task automatic data(string req, logic [7:0] b);
    sb_q.push_back(expect_wr(b));
    sb_req.push_back(req);
    xfer(1'b1, {8'h0, b}, 8);
  endtask

  task automatic modes(string req, logic [15:0] exp);
    check(req, {port, chr_on, icon_on, duty, digits, blink_rate, blink_chr, blink_icon}, exp);
  endtask

  initial begin
    ticks(3);
    rst_n = 1'b1;
    ticks(2);
    // R11 reset state
    modes("R11 modes", 16'h0);
    check("R11 strobes", {wr_en, shift_stb}, 0);
    data("R11 default target", 8'h41);
    // R4
    instr(8'h03); check("R4 port on", port, 1);
    instr(8'h02); check("R4 port off", port, 0);
    instr(8'h05); check("R4 chr only", {icon_on, chr_on}, 2'b01);
    instr(8'h06); check("R4 icon only", {icon_on, chr_on}, 2'b10);
    instr(8'h07); check("R4 both on", {icon_on, chr_on}, 2'b11);
    // R5
    instr(8'h0D); check("R5 duty", duty, 5);
    instr(8'h43); check("R5 digits", digits, 3);
    // R6
    instr(8'h3A); check("R6 blink", {blink_rate, blink_icon, blink_chr}, 5'b110_1_0);
    // R7
    instr(8'h15); check("R7 shift count", n_shift, 1); check("R7 shift fields", sh_seen, 3'b101);
    instr(8'h12); check("R7 shift count2", n_shift, 2); check("R7 shift fields2", sh_seen, 3'b010);
    // R12 unlisted opcodes
    instr(8'h00); instr(8'h01); instr(8'h18); instr(8'h48); instr(8'hA5);
    modes("R12 modes unchanged", {1'b0, 1'b1, 1'b1, 3'd5, 3'd3, 3'd6, 1'b0, 1'b1});
    check("R12 no shift", n_shift, 2);
    data("R12 pointer unchanged", 8'h77);
    // R8 / R10 character wrap
    instr(8'h8F);
    data("R10 chr 0F", 8'hAA);
    data("R10 chr wrap", 8'h55);
    // R9 icon
    instr(8'h9E);
    data("R9 icon mask", 8'hFF);
    data("R9 icon mask2", 8'h06);
    // R10 glyph skip
    instr(8'hC5);
    data("R9 glyph mask", 8'hFF);
    data("R10 glyph 06", 8'h20);
    data("R10 glyph skip", 8'h13);
    instr(8'hFE);
    data("R10 glyph 3E", 8'h01);
    data("R10 glyph wrap skip", 8'h02);
    // R2 long frames
    sb_q.push_back(expect_wr(8'h3C)); sb_req.push_back("R2 long data frame");
    xfer(1'b1, 16'h0F3C, 12);
    xfer(1'b0, {5'd0, 3'b110, 8'h09}, 11);
    check("R2 long instr frame", duty, 1);
    // R1 clocks while deselected, then short frame
    instr(8'h84);
    data("R1 pre", 8'h12);
    sdat = 1'b1;
    repeat (4) begin ticks(4); sclk = 1'b1; ticks(4); sclk = 1'b0; end
    sb_q.push_back(expect_wr(8'h25)); sb_req.push_back("R1 R2 short frame");
    xfer(1'b1, 16'h0005, 4);
    // R3 address-like byte as data
    data("R3 data not address", 8'h83);
    data("R3 pointer kept", 8'h09);
    ticks(20);
    check("R8 scoreboard drained", sb_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    ticks(150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule